// File: doc/BRIEF.md
# Byte-Lane Masked Register File

This block is the operand front end of a 32-bit core whose register specifiers are 8 bits wide. The upper nibble of a specifier names one of sixteen registers. The lower nibble is a byte-lane mask. The block has two combinational read ports and one clocked write port. A read returns only the selected byte lanes, each in its own position, with the other lanes forced to zero. A write updates only the lanes that the destination mask names.

A mask of zero selects no lanes. A build-time parameter then chooses one of two behaviours. The read either returns a constant zero or returns a whole word from a second register file that has no byte addressing. A write with a zero mask goes to that second file when it exists.

The write port also has a remap mode. In this mode the write data carries its own source mask. The selected source bytes are packed together, most significant first. They are then scattered into the destination lanes, again most significant first. This packs split selections together or spreads packed bytes apart. Instruction decode and the ALU are outside the block.

Top module: `lane_rf_top`

## Requirements
- R1: A specifier's bits [7:4] give the register number and bits [3:0] give the lane mask. Mask bit 0 maps to data bits [7:0], bit 1 to [15:8], bit 2 to [23:16] and bit 3 to [31:24].
- R2: For a nonzero mask, a read port returns the selected lanes of the addressed register unchanged in position and returns zero in every unselected lane. Mask 4'hF returns the whole word.
- R3: For a zero mask, a read returns the addressed word of the alternate file when ALT_FILE=1 and returns 32'h0 when ALT_FILE=0.
- R4: A write with a zero destination mask leaves the main file unchanged. With ALT_FILE=1 it stores the whole write word into the alternate register. With ALT_FILE=0 it has no effect.
- R5: A direct write (remap off) with a nonzero mask loads each selected lane from the same lane of the write data. It leaves every other lane and every other register unchanged.
- R6: A remap write gathers the write-data lanes named by the source mask, highest lane first. The k-th gathered byte goes into the k-th selected destination lane, counting from the highest lane. Gathered bytes beyond the destination count are dropped. Destination lanes beyond the gathered count receive zero. Unselected destination lanes keep their value.
- R7: A read in the same cycle as a write to the same register returns the old contents. The new contents are visible after the clock edge.
- R8: Active-low asynchronous reset clears every register of both files to zero.
- R9: The two read ports decode and return their specifiers independently, in the same cycle.
- R10: With the write enable low, no register of either file changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_spec_i | input | 8 | Read port A specifier (register, lane mask) |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_spec_i | input | 8 | Read port B specifier |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_spec_i | input | 8 | Destination specifier |
| wr_data_i | input | 32 | Write data |
| wr_remap_i | input | 1 | Remap mode: gather by source mask, scatter by destination mask |
| wr_src_mask_i | input | 4 | Source lane mask used in remap mode |

## Verification
Two functions can meet in one cycle. The first is a read of a register. The second is a masked or remapped write to that same register. The bench causes this on every write by pointing read port A at the destination register, with a full mask, while the write is set up. It expects the old word half a cycle before the edge and the merged word just after it. The sweeps cover every mask on both read ports and every source and destination mask pair in remap mode. A second instance built with the constant-zero option shows how the zero mask behaves without an alternate file.

// File: rtl/lane_rf_pkg.sv
package lane_rf_pkg;
  parameter int DEF_IDX_W  = 4;
  parameter int DEF_NLANE  = 4;
  parameter int DEF_LANE_W = 8;

  typedef struct packed {
    logic [DEF_IDX_W-1:0] idx;
    logic [DEF_NLANE-1:0] mask;
  } spec_t;
endpackage

// File: rtl/lane_rf_store.sv
module lane_rf_store #(
  parameter int IDX_W    = 4,
  parameter int NLANE    = 4,
  parameter int LANE_W   = 8,
  parameter bit ALT_FILE = 1'b1,
  localparam int XLEN    = NLANE * LANE_W,
  localparam int NREG    = 1 << IDX_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [NLANE-1:0]           mask_i,
  input  logic [XLEN-1:0]            data_i,
  output logic [NREG-1:0][XLEN-1:0]  main_o,
  output logic [NREG-1:0][XLEN-1:0]  alt_o
);
  logic [NREG-1:0][XLEN-1:0] main_q;
  logic [NREG-1:0][XLEN-1:0] alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= '0;
    end else if (we_i) begin
      for (int l = 0; l < NLANE; l++) begin
        if (mask_i[l]) main_q[idx_i][l*LANE_W +: LANE_W] <= data_i[l*LANE_W +: LANE_W];
      end
    end
  end

  generate
    if (ALT_FILE) begin : g_alt
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  alt_q <= '0;
        else if (we_i && mask_i == '0) alt_q[idx_i] <= data_i;
      end
    end else begin : g_no_alt
      assign alt_q = '0;
    end
  endgenerate

  assign main_o = main_q;
  assign alt_o  = alt_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(main_q) && $stable(alt_q)));

  p_alt_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mask_i == '0) |=> $stable(main_q));

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_chk_reg
      for (genvar l = 0; l < NLANE; l++) begin : g_chk_lane
        p_lane_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (we_i && idx_i == IDX_W'(r) && !mask_i[l]) |=> $stable(main_q[r][l*LANE_W +: LANE_W]));
      end
    end
  endgenerate
endmodule

// File: rtl/lane_rf_remap.sv
module lane_rf_remap #(
  parameter int NLANE  = 4,
  parameter int LANE_W = 8,
  localparam int XLEN  = NLANE * LANE_W,
  localparam int CNT_W = $clog2(NLANE + 1),
  localparam int SEL_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              remap_i,
  input  logic [NLANE-1:0]  src_mask_i,
  input  logic [NLANE-1:0]  dst_mask_i,
  input  logic [XLEN-1:0]   data_i,
  output logic [XLEN-1:0]   data_o
);
  logic [NLANE-1:0][LANE_W-1:0] pk;
  logic [CNT_W-1:0]             n_src;
  logic [CNT_W-1:0]             n_dst;
  logic [XLEN-1:0]              spread;

  // gather high lane first, then scatter high lane first
  always_comb begin
    pk     = '0;
    n_src  = '0;
    for (int l = NLANE - 1; l >= 0; l--) begin
      if (src_mask_i[l]) begin
        pk[n_src[SEL_W-1:0]] = data_i[l*LANE_W +: LANE_W];
        n_src = n_src + CNT_W'(1);
      end
    end
    spread = '0;
    n_dst  = '0;
    for (int l = NLANE - 1; l >= 0; l--) begin
      if (dst_mask_i[l]) begin
        if (n_dst < n_src) spread[l*LANE_W +: LANE_W] = pk[n_dst[SEL_W-1:0]];
        n_dst = n_dst + CNT_W'(1);
      end
    end
  end

  assign data_o = remap_i ? spread : data_i;

  p_remap_ident_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_i && &src_mask_i && &dst_mask_i) |-> data_o == data_i);

  p_remap_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_i && src_mask_i == '0) |-> data_o == '0);
endmodule

// File: rtl/lane_rf_read_port.sv
module lane_rf_read_port #(
  parameter int IDX_W  = 4,
  parameter int NLANE  = 4,
  parameter int LANE_W = 8,
  localparam int XLEN  = NLANE * LANE_W,
  localparam int NREG  = 1 << IDX_W,
  localparam int SPEC_W = IDX_W + NLANE
) (
  input  logic [SPEC_W-1:0]          spec_i,
  input  logic [NREG-1:0][XLEN-1:0]  main_i,
  input  logic [NREG-1:0][XLEN-1:0]  alt_i,
  output logic [XLEN-1:0]            data_o
);
  logic [IDX_W-1:0] idx;
  logic [NLANE-1:0] mask;
  logic [XLEN-1:0]  word;
  logic [XLEN-1:0]  masked;

  assign idx  = spec_i[SPEC_W-1 -: IDX_W];
  assign mask = spec_i[NLANE-1:0];
  assign word = main_i[idx];

  generate
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      assign masked[l*LANE_W +: LANE_W] = mask[l] ? word[l*LANE_W +: LANE_W] : '0;
    end
  endgenerate

  // alt_i is all zero when no alternate file is built
  assign data_o = (mask == '0) ? alt_i[idx] : masked;
endmodule

// File: rtl/lane_rf_top.sv
module lane_rf_top
  import lane_rf_pkg::*;
#(
  parameter int IDX_W    = DEF_IDX_W,
  parameter int NLANE    = DEF_NLANE,
  parameter int LANE_W   = DEF_LANE_W,
  parameter bit ALT_FILE = 1'b1,
  localparam int XLEN    = NLANE * LANE_W,
  localparam int NREG    = 1 << IDX_W,
  localparam int SPEC_W  = IDX_W + NLANE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SPEC_W-1:0] rd_a_spec_i,
  output logic [XLEN-1:0]   rd_a_data_o,
  input  logic [SPEC_W-1:0] rd_b_spec_i,
  output logic [XLEN-1:0]   rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [SPEC_W-1:0] wr_spec_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic              wr_remap_i,
  input  logic [NLANE-1:0]  wr_src_mask_i
);
  logic [NREG-1:0][XLEN-1:0] main_w;
  logic [NREG-1:0][XLEN-1:0] alt_w;
  logic [XLEN-1:0]           wr_word;
  logic [IDX_W-1:0]          wr_idx;
  logic [NLANE-1:0]          wr_mask;
  logic [1:0][SPEC_W-1:0]    rd_spec;
  logic [1:0][XLEN-1:0]      rd_data;

  assign wr_idx  = wr_spec_i[SPEC_W-1 -: IDX_W];
  assign wr_mask = wr_spec_i[NLANE-1:0];

  lane_rf_remap #(.NLANE(NLANE), .LANE_W(LANE_W)) u_remap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .remap_i    (wr_remap_i),
    .src_mask_i (wr_src_mask_i),
    .dst_mask_i (wr_mask),
    .data_i     (wr_data_i),
    .data_o     (wr_word)
  );

  // a zero destination mask passes the raw word to the alternate file
  lane_rf_store #(.IDX_W(IDX_W), .NLANE(NLANE), .LANE_W(LANE_W), .ALT_FILE(ALT_FILE)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i),
    .idx_i  (wr_idx),
    .mask_i (wr_mask),
    .data_i ((wr_mask == '0) ? wr_data_i : wr_word),
    .main_o (main_w),
    .alt_o  (alt_w)
  );

  assign rd_spec[0] = rd_a_spec_i;
  assign rd_spec[1] = rd_b_spec_i;

  generate
    for (genvar p = 0; p < 2; p++) begin : g_rd
      lane_rf_read_port #(.IDX_W(IDX_W), .NLANE(NLANE), .LANE_W(LANE_W)) u_port (
        .spec_i (rd_spec[p]),
        .main_i (main_w),
        .alt_i  (alt_w),
        .data_o (rd_data[p])
      );
    end
  endgenerate

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
endmodule

// File: tb/sim_lane_rf_top.sv
module sim_lane_rf_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  rd_a_spec = '0, rd_b_spec = '0, wr_spec = '0;
  logic [31:0] rd_a_data, rd_b_data, c_a_data, c_b_data, wr_data = '0;
  logic        wr_en = 1'b0, wr_remap = 1'b0;
  logic [3:0]  wr_src_mask = '0;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] ref_main [16];
  logic [31:0] ref_alt  [16];

  always #5 clk = ~clk;

  lane_rf_top #(.ALT_FILE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_a_spec_i(rd_a_spec), .rd_a_data_o(rd_a_data),
    .rd_b_spec_i(rd_b_spec), .rd_b_data_o(rd_b_data),
    .wr_en_i(wr_en), .wr_spec_i(wr_spec), .wr_data_i(wr_data),
    .wr_remap_i(wr_remap), .wr_src_mask_i(wr_src_mask));

  lane_rf_top #(.ALT_FILE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_a_spec_i(rd_a_spec), .rd_a_data_o(c_a_data),
    .rd_b_spec_i(rd_b_spec), .rd_b_data_o(c_b_data),
    .wr_en_i(wr_en), .wr_spec_i(wr_spec), .wr_data_i(wr_data),
    .wr_remap_i(wr_remap), .wr_src_mask_i(wr_src_mask));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] spec, input bit alt);
    logic [31:0] w;
    w = '0;
    if (spec[3:0] == 4'h0) return alt ? ref_alt[spec[7:4]] : 32'h0;
    for (int l = 0; l < 4; l++)
      if (spec[l]) w[l*8 +: 8] = ref_main[spec[7:4]][l*8 +: 8];
    return w;
  endfunction

  function automatic logic [31:0] remap_ref(input logic [31:0] d, input logic [3:0] s, input logic [3:0] m);
    logic [7:0]  q [4];
    int          n, k;
    logic [31:0] o;
    n = 0; k = 0; o = '0;
    for (int l = 3; l >= 0; l--) if (s[l]) begin q[n] = d[l*8 +: 8]; n++; end
    for (int l = 3; l >= 0; l--) if (m[l]) begin
      if (k < n) o[l*8 +: 8] = q[k];
      k++;
    end
    return o;
  endfunction

  task automatic do_write(input logic [7:0] spec, input logic [31:0] d, input logic rmp, input logic [3:0] sm);
    logic [31:0] w;
    @(negedge clk);
    wr_en = 1'b1; wr_spec = spec; wr_data = d; wr_remap = rmp; wr_src_mask = sm;
    rd_a_spec = {spec[7:4], 4'hF};
    #1;
    chk("R7 old value during write", rd_a_data, ref_main[spec[7:4]]);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (spec[3:0] == 4'h0) ref_alt[spec[7:4]] = d;
    else begin
      w = rmp ? remap_ref(d, sm, spec[3:0]) : d;
      for (int l = 0; l < 4; l++)
        if (spec[l]) ref_main[spec[7:4]][l*8 +: 8] = w[l*8 +: 8];
    end
    chk("R7 new value after edge", rd_a_data, ref_main[spec[7:4]]);
  endtask

  task automatic check_all(input string tag);
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      rd_a_spec = {4'(r), 4'hF};
      rd_b_spec = {4'(r), 4'h0};
      #1;
      chk({tag, " main"}, rd_a_data, ref_main[r]);
      chk({tag, " alt"}, rd_b_data, ref_alt[r]);
      chk({tag, " const R3"}, c_b_data, 32'h0);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++) begin ref_main[r] = '0; ref_alt[r] = '0; end
    repeat (3) @(posedge clk);
    check_all("R8 reset");
    @(negedge clk); rst_ni = 1'b1;

    // fill both files
    for (int r = 0; r < 16; r++) begin
      do_write({4'(r), 4'hF}, 32'h9E3779B9 * (r + 1), 1'b0, 4'h0);
      do_write({4'(r), 4'h0}, 32'h5851F42D ^ (32'(r) << 20) ^ 32'(r * 77), 1'b0, 4'h0);
    end
    check_all("R4 fill");

    // R1 R2 R3 R9: every register, every mask, both ports, both variants
    for (int r = 0; r < 16; r++) begin
      for (int m = 0; m < 16; m++) begin
        @(negedge clk);
        rd_a_spec = {4'(r), 4'(m)};
        rd_b_spec = {4'(15 - r), 4'(15 - m)};
        #1;
        chk("R2 R3 port A", rd_a_data, exp_rd(rd_a_spec, 1'b1));
        chk("R1 R9 port B", rd_b_data, exp_rd(rd_b_spec, 1'b1));
        chk("R3 const port A", c_a_data, exp_rd(rd_a_spec, 1'b0));
        chk("R3 const port B", c_b_data, exp_rd(rd_b_spec, 1'b0));
      end
    end

    // R5: direct writes with every mask
    for (int m = 0; m < 16; m++)
      do_write({4'd9, 4'(m)}, 32'hC0DE0000 + 32'(m * 4099), 1'b0, 4'h0);
    check_all("R5 R4 masked");

    // R6: every source and destination mask pair
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 16; d++) begin
        do_write({4'd5, 4'(d)}, 32'hA1B2C3D4 ^ 32'(s * 16 + d), 1'b1, 4'(s));
        @(negedge clk);
        rd_a_spec = 8'h5F; rd_b_spec = 8'h50;
        #1;
        chk("R6 remap main", rd_a_data, ref_main[5]);
        chk("R6 remap alt", rd_b_data, ref_alt[5]);
        chk("R6 remap const file", c_a_data, ref_main[5]);
      end
    end
    check_all("R6 others");

    // R10: enable low with live data
    @(negedge clk);
    wr_en = 1'b0; wr_spec = 8'h3F; wr_data = 32'hDEADBEEF; wr_remap = 1'b0;
    repeat (2) @(posedge clk);
    check_all("R10 idle");

    // R8: asynchronous reset mid-run
    @(negedge clk);
    #2 rst_ni = 1'b0;
    #1;
    for (int r = 0; r < 16; r++) begin ref_main[r] = '0; ref_alt[r] = '0; end
    rd_a_spec = 8'h9F; rd_b_spec = 8'h50;
    #1;
    chk("R8 async main", rd_a_data, 32'h0);
    chk("R8 async alt", rd_b_data, 32'h0);
    check_all("R8 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule